// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Gate

This block owns the status byte of a small serial flash and rules on every command that would change the array or the status byte. The command decoder in front of it sends one-cycle strobes for the following commands:

- latch enable and latch disable;
- status write, with its data byte;
- page program, sector erase, block erase and whole-array erase, each with a target address.

The block answers every write-type strobe with exactly one pulse, either grant or reject. On a grant it starts a busy window whose length depends on the operation.

The status byte is always visible on `status_o`, so a read-status path can return it at any time, including during a busy window. The block holds four status fields: the write-enable latch, the busy flag, three block-protect bits and a status-lock bit. The block-protect bits and the status-lock bit behave as non-volatile cells. They start at 0 and keep their values across the reset input. The write-enable latch and the busy flag are cleared by reset.

Protection works at two levels. A status write is refused only when the status-lock bit is 1 and the hardware protect pin is held low. Program and erase requests are refused when the block-protect code covers the target address. A whole-array erase additionally needs every block-protect bit to be 0.

Top module: `flash_wp_ctrl`

## Requirements
- R1: `status_o` bit 7 is the status-lock bit, bits 6:5 read 0, bits 4:2 are the block-protect bits BP2..BP0, bit 1 is the write-enable latch, and bit 0 is the busy flag. After power-up and reset the byte reads 00h.
- R2: When not busy, a latch-enable strobe sets bit 1 and a latch-disable strobe clears it. The new value shows one cycle after the strobe.
- R3: A status write, program or erase issued while bit 1 is 0 is rejected and changes no state.
- R4: A granted status write copies data bit 7 to the status-lock bit and data bits 4:2 to BP2..BP0. All other data bits are ignored. The write is rejected only when the status-lock bit is 1 and `wprot_ni` is 0.
- R5: Block-protect codes with BP1 = BP0 = 1 protect every address, and program, sector erase and block erase are then rejected. All other codes protect nothing, whatever the value of BP2.
- R6: A whole-array erase is granted only when BP2..BP0 are all 0.
- R7: A grant sets bit 0 for exactly WRSR_CYC, PROG_CYC or ERASE_CYC cycles, matching the operation. Bit 1 clears on the same edge that clears bit 0.
- R8: While bit 0 is 1, every write-type strobe is rejected, latch-enable and latch-disable strobes have no effect, and `status_o` stays readable.
- R9: Asserting `rst_ni` clears bits 1 and 0, including mid-operation. Bits 7 and 4:2 keep their values.
- R10: Every write-type strobe produces exactly one one-cycle pulse, on `grant_o` or on `reject_o`, in the cycle after the strobe. The two pulses never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the volatile state |
| wprot_ni | input | 1 | Hardware protect pin, active low |
| wren_i | input | 1 | Latch-enable strobe |
| wrdi_i | input | 1 | Latch-disable strobe |
| wrsr_i | input | 1 | Status-write strobe |
| wrsr_data_i | input | 8 | Status-write data byte |
| prog_i | input | 1 | Page-program strobe |
| sect_erase_i | input | 1 | Sector-erase strobe |
| blk_erase_i | input | 1 | Block-erase strobe |
| chip_erase_i | input | 1 | Whole-array erase strobe |
| addr_i | input | ADDR_W | Target address for program and erase |
| status_o | output | 8 | Status byte |
| grant_o | output | 1 | One-cycle pulse: write-type command accepted |
| reject_o | output | 1 | One-cycle pulse: write-type command dropped |

## Verification
The bench sweeps all eight block-protect codes with the status-lock bit at both values, and tries every program and erase kind with the latch both clear and set. This catches three kinds of faulty decode: one that reads BP2, one that protects on a single set bit, or one that lets a whole-array erase through with a nonzero BP2.

All eight combinations of status-lock bit, protect pin and latch are applied to a status write. A design that ANDs the wrong polarity, or ignores the latch, grants or refuses the wrong cases.

The busy window is counted edge by edge for every granted operation, which exposes off-by-one timers and a latch that clears at the wrong edge. Latch-disable, status-write and program strobes are issued mid-window, which exposes a design that lets them act while busy.

A reset pulse is then applied to check that the protect bits survive it while the latch and the busy flag clear. This also covers a reset taken during an erase.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WRSR,
    OP_PROG,
    OP_SECT,
    OP_BLK,
    OP_CHIP
  } wr_op_e;

  typedef struct packed {
    logic       srwd;
    logic [1:0] rsvd;
    logic [2:0] bp;
    logic       wel;
    logic       wip;
  } status_t;

  localparam int unsigned BP_W = 3;

endpackage

// File: rtl/fwp_nv_regs.sv
module fwp_nv_regs
  import flash_wp_pkg::*;
(
  input  logic            clk_i,
  input  logic            upd_i,
  input  logic            srwd_d_i,
  input  logic [BP_W-1:0] bp_d_i,
  output logic            srwd_o,
  output logic [BP_W-1:0] bp_o
);

  // Model of non-volatile cells: power-up value 0, untouched by reset.
  logic            srwd_q = 1'b0;
  logic [BP_W-1:0] bp_q   = '0;

  always_ff @(posedge clk_i) begin
    if (upd_i) begin
      srwd_q <= srwd_d_i;
      bp_q   <= bp_d_i;
    end
  end

  assign srwd_o = srwd_q;
  assign bp_o   = bp_q;

endmodule

// File: rtl/fwp_gate.sv
module fwp_gate
  import flash_wp_pkg::*;
#(
  parameter int unsigned     ADDR_W     = 15,
  parameter logic [ADDR_W-1:0] PROT_MASK  = '0,
  parameter logic [ADDR_W-1:0] PROT_MATCH = '0
) (
  input  wr_op_e            op_i,
  input  logic              wel_i,
  input  logic              busy_i,
  input  logic              srwd_i,
  input  logic [BP_W-1:0]   bp_i,
  input  logic              wprot_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              is_write_o,
  output logic              allow_o
);

  logic full_code;
  logic addr_hit;
  logic region_prot;
  logic sr_locked;

  assign full_code   = (bp_i[1:0] == 2'b11);
  assign addr_hit    = ((addr_i & PROT_MASK) == (PROT_MATCH & PROT_MASK));
  assign region_prot = full_code && addr_hit;
  assign sr_locked   = srwd_i && !wprot_ni;
  assign is_write_o  = (op_i != OP_NONE);

  always_comb begin
    allow_o = 1'b0;
    if (wel_i && !busy_i) begin
      unique case (op_i)
        OP_WRSR: allow_o = !sr_locked;
        OP_PROG,
        OP_SECT,
        OP_BLK:  allow_o = !region_prot;
        OP_CHIP: allow_o = (bp_i == '0);
        default: allow_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/fwp_busy_timer.sv
module fwp_busy_timer
  import flash_wp_pkg::*;
#(
  parameter int unsigned WRSR_CYC  = 40,
  parameter int unsigned PROG_CYC  = 200,
  parameter int unsigned ERASE_CYC = 700
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  wr_op_e op_i,
  output logic   busy_o,
  output logic   done_o
);

  localparam int unsigned MAX_A   = (WRSR_CYC > PROG_CYC) ? WRSR_CYC : PROG_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > ERASE_CYC) ? MAX_A : ERASE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             busy_q;

  always_comb begin
    unique case (op_i)
      OP_WRSR: load_val = CNT_W'(WRSR_CYC);
      OP_PROG: load_val = CNT_W'(PROG_CYC);
      default: load_val = CNT_W'(ERASE_CYC);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= load_val;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 15,
  parameter logic [ADDR_W-1:0] PROT_MASK  = '0,
  parameter logic [ADDR_W-1:0] PROT_MATCH = '0,
  parameter int unsigned       WRSR_CYC   = 40,
  parameter int unsigned       PROG_CYC   = 200,
  parameter int unsigned       ERASE_CYC  = 700
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wprot_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              prog_i,
  input  logic              sect_erase_i,
  input  logic              blk_erase_i,
  input  logic              chip_erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        status_o,
  output logic              grant_o,
  output logic              reject_o
);

  wr_op_e          op;
  logic            is_write;
  logic            allow;
  logic            start;
  logic            busy;
  logic            done;
  logic            wel_q;
  logic            srwd;
  logic [BP_W-1:0] bp;
  logic            grant_q;
  logic            reject_q;
  status_t         st;

  // Decoder sends one strobe per cycle; fixed priority if it does not.
  always_comb begin
    if      (wrsr_i)       op = OP_WRSR;
    else if (prog_i)       op = OP_PROG;
    else if (sect_erase_i) op = OP_SECT;
    else if (blk_erase_i)  op = OP_BLK;
    else if (chip_erase_i) op = OP_CHIP;
    else                   op = OP_NONE;
  end

  fwp_gate #(
    .ADDR_W    (ADDR_W),
    .PROT_MASK (PROT_MASK),
    .PROT_MATCH(PROT_MATCH)
  ) u_gate (
    .op_i      (op),
    .wel_i     (wel_q),
    .busy_i    (busy),
    .srwd_i    (srwd),
    .bp_i      (bp),
    .wprot_ni  (wprot_ni),
    .addr_i    (addr_i),
    .is_write_o(is_write),
    .allow_o   (allow)
  );

  assign start = is_write && allow;

  fwp_busy_timer #(
    .WRSR_CYC (WRSR_CYC),
    .PROG_CYC (PROG_CYC),
    .ERASE_CYC(ERASE_CYC)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .op_i   (op),
    .busy_o (busy),
    .done_o (done)
  );

  fwp_nv_regs u_nv (
    .clk_i   (clk_i),
    .upd_i   (start && (op == OP_WRSR)),
    .srwd_d_i(wrsr_data_i[7]),
    .bp_d_i  (wrsr_data_i[4:2]),
    .srwd_o  (srwd),
    .bp_o    (bp)
  );

  logic unused_wdata;
  assign unused_wdata = ^{wrsr_data_i[6:5], wrsr_data_i[1:0]};

  // Latch stays set through the busy window and drops as it ends.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q <= 1'b0;
    end else if (done) begin
      wel_q <= 1'b0;
    end else if (!busy) begin
      if (wren_i)      wel_q <= 1'b1;
      else if (wrdi_i) wel_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      grant_q  <= start;
      reject_q <= is_write && !allow;
    end
  end

  always_comb begin
    st.srwd = srwd;
    st.rsvd = 2'b00;
    st.bp   = bp;
    st.wel  = wel_q;
    st.wip  = busy;
  end

  assign status_o = st;
  assign grant_o  = grant_q;
  assign reject_o = reject_q;

endmodule

// File: rtl/flash_wp_chk.sv
module flash_wp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wprot_ni,
  input logic       wren_i,
  input logic       wrsr_i,
  input logic       prog_i,
  input logic       sect_erase_i,
  input logic       blk_erase_i,
  input logic       chip_erase_i,
  input logic [7:0] status_o,
  input logic       grant_o,
  input logic       reject_o
);

  logic any_wr;
  assign any_wr = wrsr_i || prog_i || sect_erase_i || blk_erase_i || chip_erase_i;

  // R10
  grant_reject_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && reject_o));

  // R10
  write_answered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_wr |=> (grant_o || reject_o));

  // R3
  grant_needs_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> $past(status_o[1]));

  // R7
  grant_sets_wip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> status_o[0]);

  // R7
  wip_end_clears_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[0]) |-> !status_o[1]);

  // R4
  hw_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrsr_i && status_o[7] && !wprot_ni) |=> reject_o);

  // R6
  chip_bp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_erase_i && !wrsr_i && !prog_i && !sect_erase_i && !blk_erase_i
     && (status_o[4:2] != 3'b000)) |=> reject_o);

  // R8
  busy_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && any_wr) |=> reject_o);

  // R2
  wren_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wren_i && !status_o[0]) |=> status_o[1]);

endmodule

bind flash_wp_ctrl flash_wp_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wprot_ni    (wprot_ni),
  .wren_i      (wren_i),
  .wrsr_i      (wrsr_i),
  .prog_i      (prog_i),
  .sect_erase_i(sect_erase_i),
  .blk_erase_i (blk_erase_i),
  .chip_erase_i(chip_erase_i),
  .status_o    (status_o),
  .grant_o     (grant_o),
  .reject_o    (reject_o)
);

// File: tb/sim_flash_wp_ctrl.sv
module sim_flash_wp_ctrl;

  localparam int WRSR_N  = 3;
  localparam int PROG_N  = 5;
  localparam int ERASE_N = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wprot_n = 1'b1;
  logic        wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic        prog = 1'b0, sect = 1'b0, blk = 1'b0, chip = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  status;
  logic        grant, reject;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  flash_wp_ctrl #(
    .ADDR_W   (15),
    .WRSR_CYC (WRSR_N),
    .PROG_CYC (PROG_N),
    .ERASE_CYC(ERASE_N)
  ) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wprot_ni    (wprot_n),
    .wren_i      (wren),
    .wrdi_i      (wrdi),
    .wrsr_i      (wrsr),
    .wrsr_data_i (wdata),
    .prog_i      (prog),
    .sect_erase_i(sect),
    .blk_erase_i (blk),
    .chip_erase_i(chip),
    .addr_i      (addr),
    .status_o    (status),
    .grant_o     (grant),
    .reject_o    (reject)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 wren, 1 wrdi, 2 wrsr, 3 prog, 4 sector, 5 block, 6 chip
  task automatic strobe(input int kind, input logic [7:0] d, input logic [14:0] a,
                        output logic g, output logic r);
    @(negedge clk);
    wdata = d;
    addr  = a;
    wren  = (kind == 0);
    wrdi  = (kind == 1);
    wrsr  = (kind == 2);
    prog  = (kind == 3);
    sect  = (kind == 4);
    blk   = (kind == 5);
    chip  = (kind == 6);
    @(negedge clk);
    {wren, wrdi, wrsr, prog, sect, blk, chip} = '0;
    g = grant;
    r = reject;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (status[0] && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Counts samples with busy set, starting at the grant sample.
  task automatic busy_len(output int n);
    n = 0;
    while (status[0] && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic set_status(input logic [2:0] bpv, input logic sv);
    logic g, r;
    wprot_n = 1'b1;
    strobe(0, 8'h00, '0, g, r);
    strobe(2, {sv, 2'b11, bpv, 2'b11}, '0, g, r);
    check("R4 status write granted", g, 1);
    wait_idle();
    check("R4/R1 status after write", status, {sv, 2'b00, bpv, 2'b00});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic g, r;
    int   n;
    int   exp_g;
    int   exp_n;
    logic [7:0] exp_st;

    repeat (3) @(negedge clk);
    check("R1 status under reset", status, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after reset", status, 8'h00);
    check("R10 no pulse idle", {grant, reject}, 0);

    // R2
    strobe(0, 8'h00, '0, g, r);
    check("R2 latch set", status[1], 1);
    check("R10 latch-enable no pulse", {g, r}, 0);
    strobe(1, 8'h00, '0, g, r);
    check("R2 latch clear", status[1], 0);

    // R3
    strobe(3, 8'h00, 15'h0123, g, r);
    check("R3 program without latch", {g, r}, 2'b01);
    check("R3 no busy", status[0], 0);
    strobe(2, 8'h9C, '0, g, r);
    check("R3 status write without latch", {g, r}, 2'b01);
    check("R3 status unchanged", status, 8'h00);

    // R5 R6 R7 sweep over protect codes, lock bit, op kinds and latch
    for (int bpv = 0; bpv < 8; bpv++) begin
      for (int sv = 0; sv < 2; sv++) begin
        set_status(3'(bpv), 1'(sv));
        for (int k = 3; k <= 6; k++) begin
          for (int w = 0; w < 2; w++) begin
            if (w == 1) strobe(0, 8'h00, '0, g, r);
            else        strobe(1, 8'h00, '0, g, r);
            strobe(k, 8'h00, 15'((bpv * 37 + k * 4099 + w * 911 + sv * 5) & 16'h7fff), g, r);
            if (k == 6) exp_g = (w == 1) && (bpv == 0);
            else        exp_g = (w == 1) && ((bpv & 3) != 3);
            check(k == 6 ? "R6 chip erase gate" : "R5 region gate", {g, r}, {exp_g[0], ~exp_g[0]});
            if (exp_g != 0) begin
              busy_len(n);
              exp_n = (k == 3) ? PROG_N : ERASE_N;
              check("R7 busy length", n, exp_n);
              check("R7 latch cleared at end", status[1], 0);
            end else begin
              check("R3/R5 rejected keeps state", status, {1'(sv), 2'b00, 3'(bpv), 1'(w), 1'b0});
            end
          end
        end
      end
    end

    // R4 status write lock: lock bit x pin x latch
    for (int sv = 0; sv < 2; sv++) begin
      for (int wp = 0; wp < 2; wp++) begin
        for (int w = 0; w < 2; w++) begin
          set_status(3'b000, 1'(sv));
          wprot_n = 1'(wp);
          if (w == 1) strobe(0, 8'h00, '0, g, r);
          else        strobe(1, 8'h00, '0, g, r);
          strobe(2, {~1'(sv), 2'b11, 3'b010, 2'b11}, '0, g, r);
          exp_g = (w == 1) && !(sv == 1 && wp == 0);
          check("R4 lock gate", {g, r}, {exp_g[0], ~exp_g[0]});
          if (exp_g != 0) begin
            busy_len(n);
            check("R7 status write busy length", n, WRSR_N);
            exp_st = {~1'(sv), 2'b00, 3'b010, 2'b00};
          end else begin
            exp_st = {1'(sv), 2'b00, 3'b000, 1'(w), 1'b0};
          end
          check("R4 status after lock test", status, exp_st);
          wprot_n = 1'b1;
        end
      end
    end

    // R8 commands during busy
    set_status(3'b000, 1'b0);
    strobe(0, 8'h00, '0, g, r);
    strobe(4, 8'h00, 15'h1000, g, r);
    check("R8 erase granted", {g, r}, 2'b10);
    strobe(1, 8'h00, '0, g, r);
    check("R8 latch-disable ignored while busy", status[1:0], 2'b11);
    strobe(2, 8'h9C, '0, g, r);
    check("R8 status write rejected while busy", {g, r}, 2'b01);
    check("R8 status readable while busy", status, 8'h03);
    strobe(3, 8'h00, 15'h0001, g, r);
    check("R8 program rejected while busy", {g, r}, 2'b01);
    wait_idle();
    check("R8 idle after window", status, 8'h00);
    strobe(0, 8'h00, '0, g, r);
    check("R2 latch set after window", status[1], 1);

    // R9 reset keeps protect bits, clears volatile ones
    set_status(3'b101, 1'b1);
    strobe(0, 8'h00, '0, g, r);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 protect bits kept", status, 8'b1_00_101_00);
    strobe(0, 8'h00, '0, g, r);
    strobe(5, 8'h00, 15'h4000, g, r);
    check("R5 code 101 protects nothing", {g, r}, 2'b10);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset mid-erase", status, 8'b1_00_101_00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule